// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

The block produces four independent left-aligned 8-bit pulse-width-modulated outputs from one system clock. Channels are grouped in two pairs. Each pair has a binary prescaler that divides the system clock by 2^N. After it comes an optional scaler that divides the prescaled rate by a further 2(M+1). Each channel picks one of its pair's two tick rates. Each channel also has its own period, duty, polarity and enable settings.

Software programs the block through a write-only port made of an address, a data byte and a strobe. Each channel counts ticks from 0 up to its period value and then wraps to 0. A channel's output sits at its active level from count 0 through its duty value, and at the inactive level for the rest of the period. New period and duty values wait in a shadow stage until the current period ends, so no cycle is ever cut short.

Top module: `pwm4_top`

## Requirements
- R1: With the prescaled tick selected, a channel's period is 2^N × (P+1) system clocks. N for channels 0 and 1 sits in bits 5:3 of the clock register (address 0). N for channels 2 and 3 sits in bits 2:0 of the same register.
- R2: With the scaled tick selected, the period is 2^(N+1) × (M+1) × (P+1) system clocks. M for channels 0 and 1 is the byte at address 3. M for channels 2 and 3 is the byte at address 4.
- R3: At address 1, bit i (i = 0..3) sets the active level of channel i, where 1 means active high. Bit 4+i selects the clock for channel i, where 1 means the scaled tick and 0 means the prescaled tick.
- R4: The period value P of channel i is written at address 8+i and the duty value D at address 12+i. Within each period the output is active for (D+1) tick intervals. When D ≥ P the output stays active throughout.
- R5: An enabled channel's counter never exceeds the period value in use. After the tick on which it equals that value, it returns to 0.
- R6: Bit i at address 2 enables channel i. While a channel is disabled, its counter is held at 0 and its output sits at the inactive level (the inverse of its polarity bit). After enabling, the first period starts at count 0 and the output is active at once.
- R7: A period or duty write made while a channel runs does not change the period in progress. It takes effect from the next period.
- R8: After reset all settings are zero, every channel is disabled, and all four outputs are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_o | output | 4 | PWM outputs, bit i for channel i |

## Verification
The assertions assume that writes reach the block only through the strobe port, and that the strobe lasts one clock per write. They also assume the period and duty inputs may change at any time, which is why the shadow registers are checked rather than the raw settings. The bench stays within these assumptions by issuing every write as a single-cycle strobe on the falling clock edge. It disables all channels before changing the clock settings, so each measured period starts from a known counter state. It skips the first boundary after enabling whenever the prescaler phase is unknown.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int NCH   = 4;   // channels
    localparam int NPAIR = NCH / 2;
    localparam int DW    = 8;   // data / counter width
    localparam int NW    = 3;   // prescaler exponent width
    localparam int AW    = 4;   // address width

    localparam int A_CLK = 0;
    localparam int A_POL = 1;
    localparam int A_EN  = 2;
    localparam int A_SCL = 3;   // A_SCL + pair
    localparam int A_PER = 8;   // A_PER + channel
    localparam int A_DTY = 12;  // A_DTY + channel

    typedef struct packed {
        logic [DW-1:0]             clkcfg;
        logic [DW-1:0]             polsel;
        logic [NCH-1:0]            en;
        logic [NPAIR-1:0][DW-1:0]  scale;
        logic [NCH-1:0][DW-1:0]    per;
        logic [NCH-1:0][DW-1:0]    dty;
    } regs_t;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [DW-1:0]              wr_data,
    output logic [NPAIR-1:0][NW-1:0]   n_pair,
    output logic [NPAIR-1:0][DW-1:0]   m_pair,
    output logic [NCH-1:0]             pol,
    output logic [NCH-1:0]             sel,
    output logic [NCH-1:0]             en,
    output logic [NCH-1:0][DW-1:0]     per,
    output logic [NCH-1:0][DW-1:0]     dty
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == AW'(A_CLK)) r_d.clkcfg = wr_data;
            if (wr_addr == AW'(A_POL)) r_d.polsel = wr_data;
            if (wr_addr == AW'(A_EN))  r_d.en     = wr_data[NCH-1:0];
            for (int p = 0; p < NPAIR; p++) begin
                if (wr_addr == AW'(A_SCL + p)) r_d.scale[p] = wr_data;
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(A_PER + i)) r_d.per[i] = wr_data;
                if (wr_addr == AW'(A_DTY + i)) r_d.dty[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // pair p exponent: pair 0 in the upper field, pair 1 in the lower
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign n_pair[p] = r_q.clkcfg[(NPAIR-1-p)*NW +: NW];
        assign m_pair[p] = r_q.scale[p];
    end

    assign pol = r_q.polsel[NCH-1:0];
    assign sel = r_q.polsel[2*NCH-1:NCH];
    assign en  = r_q.en;
    assign per = r_q.per;
    assign dty = r_q.dty;
endmodule

// File: rtl/pwm4_clkgen.sv
module pwm4_clkgen #(
    parameter int DW = 8,
    parameter int NW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] n,
    input  logic [DW-1:0] m,
    output logic          pre_tick,
    output logic          sc_tick
);
    localparam int PW = (1 << NW) - 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [DW-1:0] sc;
        logic          half;
    } cg_t;

    cg_t s_d, s_q;
    logic [PW-1:0] mask;

    always_comb begin
        mask     = (PW'(1) << n) - PW'(1);
        pre_tick = (s_q.pre & mask) == mask;
        sc_tick  = pre_tick && (s_q.sc >= m) && s_q.half;
        s_d      = s_q;
        s_d.pre  = s_q.pre + PW'(1);
        if (pre_tick) begin
            if (s_q.sc >= m) begin
                s_d.sc   = '0;
                s_d.half = ~s_q.half;
            end else begin
                s_d.sc = s_q.sc + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: with no division every system clock is a prescaled tick
    p_pre_every_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (n == '0) |-> pre_tick);

    // R2: the divide-by-two stage flips each time the scaler wraps
    p_half_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && s_q.sc == m) |=> (s_q.half != $past(s_q.half)));
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pol,
    input  logic          tick,
    input  logic [DW-1:0] per,
    input  logic [DW-1:0] dty,
    output logic          out
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] per_sh;
        logic [DW-1:0] dty_sh;
    } ch_t;

    ch_t c_d, c_q;
    logic wrap;

    always_comb begin
        c_d  = c_q;
        wrap = tick && (c_q.cnt >= c_q.per_sh);
        if (!en) begin
            c_d.cnt    = '0;
            c_d.per_sh = per;
            c_d.dty_sh = dty;
        end else if (wrap) begin
            c_d.cnt    = '0;
            c_d.per_sh = per;
            c_d.dty_sh = dty;
        end else if (tick) begin
            c_d.cnt = c_q.cnt + DW'(1);
        end
        out = (en && c_q.cnt <= c_q.dty_sh) ? pol : ~pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R5: the count stays within the period in use
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (c_q.cnt <= c_q.per_sh));

    // R5: the tick at the top of the period returns the count to zero
    p_wrap_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && c_q.cnt == c_q.per_sh) |=> (c_q.cnt == '0));

    // R6: a disabled channel holds its count at zero
    p_idle_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (c_q.cnt == '0));

    // R7: shadow values only move at a period boundary while running
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(tick && c_q.cnt == c_q.per_sh)) |=>
            ($stable(c_q.per_sh) && $stable(c_q.dty_sh)));
endmodule

// File: rtl/pwm4_top.sv
module pwm4_top
    import pwm4_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [3:0]     wr_addr,
    input  logic [7:0]     wr_data,
    output logic [3:0]     pwm_o
);
    logic [NPAIR-1:0][NW-1:0] n_pair;
    logic [NPAIR-1:0][DW-1:0] m_pair;
    logic [NCH-1:0]           pol, sel, en;
    logic [NCH-1:0][DW-1:0]   per, dty;
    logic [NPAIR-1:0]         pre_tick, sc_tick;

    pwm4_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .n_pair  (n_pair),
        .m_pair  (m_pair),
        .pol     (pol),
        .sel     (sel),
        .en      (en),
        .per     (per),
        .dty     (dty)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_clk
        pwm4_clkgen #(.DW(DW), .NW(NW)) u_clkgen (
            .clk      (clk),
            .rst_n    (rst_n),
            .n        (n_pair[p]),
            .m        (m_pair[p]),
            .pre_tick (pre_tick[p]),
            .sc_tick  (sc_tick[p])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic tick_i;
        assign tick_i = sel[i] ? sc_tick[i/2] : pre_tick[i/2];

        pwm4_chan #(.DW(DW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en[i]),
            .pol   (pol[i]),
            .tick  (tick_i),
            .per   (per[i]),
            .dty   (dty[i]),
            .out   (pwm_o[i])
        );

        // R6: a disabled channel shows the inverse of its polarity bit
        p_off_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> (pwm_o[i] == ~pol[i]));

        // R2: a scaled tick only ever lands on a prescaled tick
        p_sc_on_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[i] && tick_i) |-> pre_tick[i/2]);
    end
endmodule

// File: tb/sim_pwm4_top.sv
`timescale 1ns/1ps
module sim_pwm4_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pwm_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    pwm4_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // waits until channel ch turns from inactive to active
    task automatic wait_edge(input int ch, input logic act);
        logic prev;
        prev = pwm_o[ch];
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (pwm_o[ch] == act && prev != act) return;
            prev = pwm_o[ch];
        end
        check("edge timeout", 0, 1);
    endtask

    // called at the first active sample of a period; ends at the next one
    task automatic count_period(input int ch, input logic act,
                                output int per_c, output int hi_c);
        logic prev;
        per_c = 1; hi_c = 1; prev = act;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (pwm_o[ch] == act && prev != act) return;
            per_c++;
            if (pwm_o[ch] == act) hi_c++;
            prev = pwm_o[ch];
        end
        check("period timeout", 0, 1);
    endtask

    initial begin
        int p, h;
        logic [3:0] polv;
        polv = 4'b1010;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset outputs", int'(pwm_o), 15);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 outputs after release", int'(pwm_o), 15);

        // R3/R6: polarity takes effect on idle level
        wr(4'd1, {4'b0000, polv});
        check("R6 idle level follows polarity", int'(pwm_o), 5);

        // R6: restart from 0 on enable, N=0 prescaled, period 5, duty 2
        wr(4'd0, 8'h00);
        wr(4'd8, 8'd4);
        wr(4'd12, 8'd1);
        wr(4'd2, 8'h01);
        check("R6 active right after enable", int'(pwm_o[0]), 0);
        count_period(0, 1'b0, p, h);
        check("R6 first period length", p, 5);
        check("R6 first active time", h, 2);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pwm_o[1] != 1'b0) check("R6 ch1 disabled stays inactive", int'(pwm_o[1]), 0);
        end
        check("R6 ch1 inactive while ch0 runs", int'(pwm_o[1]), 0);

        // R7: period write mid-period
        wait_edge(0, 1'b0);
        fork
            count_period(0, 1'b0, p, h);
            wr(4'd8, 8'd7);
        join
        check("R7 period unchanged in progress", p, 5);
        count_period(0, 1'b0, p, h);
        check("R7 new period next", p, 8);
        check("R7 duty kept", h, 2);
        // R7: duty write mid-period
        fork
            count_period(0, 1'b0, p, h);
            wr(4'd12, 8'd5);
        join
        check("R7 duty unchanged in progress", h, 2);
        count_period(0, 1'b0, p, h);
        check("R7 new duty next", h, 6);
        check("R5 period with new duty", p, 8);

        // R4: duty >= period keeps output active
        wr(4'd2, 8'h00);
        check("R6 disable returns idle", int'(pwm_o[0]), 1);
        wr(4'd10, 8'd3);
        wr(4'd14, 8'd200);
        wr(4'd2, 8'h04);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (pwm_o[2] != 1'b0) bad++;
            end
            check("R4 full duty always active", bad, 0);
        end

        // R1/R2/R3/R4/R5: sweep
        for (int ch = 0; ch < 4; ch++) begin
            for (int n = 0; n < 3; n++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int m = 0; m < 1 + s; m++) begin
                        for (int pi = 0; pi < 2; pi++) begin
                            for (int di = 0; di < 2; di++) begin
                                int per_v, dty_v, t, ep, eh;
                                logic act;
                                per_v = 2 + pi;
                                dty_v = (di == 1) ? per_v - 1 : 0;
                                t = (s == 1) ? (1 << (n + 1)) * (m + 1) : (1 << n);
                                ep = (per_v + 1) * t;
                                eh = (dty_v + 1) * t;
                                act = polv[ch];
                                wr(4'd2, 8'h00);
                                wr(4'd0, 8'((n << 3) | n));
                                wr(4'd3, 8'(m));
                                wr(4'd4, 8'(m));
                                wr(4'd1, {(s == 1) ? 4'hF : 4'h0, polv});
                                wr(4'(8 + ch), 8'(per_v));
                                wr(4'(12 + ch), 8'(dty_v));
                                wr(4'd2, 8'(1 << ch));
                                wait_edge(ch, act);
                                wait_edge(ch, act);
                                count_period(ch, act, p, h);
                                if (s == 1) begin
                                    check("R2 scaled period", p, ep);
                                    check("R4 R3 scaled active time", h, eh);
                                end else begin
                                    check("R1 prescaled period", p, ep);
                                    check("R4 R3 prescaled active time", h, eh);
                                end
                            end
                        end
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule